// File: doc/BRIEF.md
# Dual-Compare Waveform Timer

This block is a free-running up-counter with two compare registers that shapes a single timer output pin. The counter advances by one on each count-clock enable pulse while the run enable is high. It returns to zero on the count clock that arrives while it holds the compare B value, so compare B sets the period. Compare A marks a point inside that period.

Each compare match can change the output pin. A 2-bit mode picks the action:
- disabled;
- driven active on A and inactive on B;
- toggled on A only;
- toggled on B only.

An invert input selects active-low operation. Each match also sets a sticky interrupt flag. The flag stays set until software strobes its clear input. A single interrupt request combines the enabled flags.

The counter reset is synchronous. It returns the count to zero and puts the pin at its inactive level. It is used to restart a waveform cleanly before enabling the run input.

Top module: `cwt_top`

## Requirements
- R1: The count advances by exactly one on a clock edge at which `run` and `cnt_en` are both 1. On every other edge it holds, unless `cnt_clr` or reset is applied.
- R2: On a count clock that arrives while the count equals `cmp_b`, the count becomes 0. With `cmp_a`=3 and `cmp_b`=5, starting from 0, the count sequence is 0,1,2,3,4,5,0,1.
- R3: With `out_mode`=0, the output holds its inactive level from the next edge onwards, whatever the matches do.
- R4: With `out_mode`=1, a compare A match makes the output active and a compare B match makes it inactive. If both match on the same count clock, the output becomes inactive.
- R5: With `out_mode`=2, a compare A match toggles the output and a compare B match leaves it unchanged.
- R6: With `out_mode`=3, a compare B match toggles the output and a compare A match leaves it unchanged.
- R7: `wave_out` is the internal non-inverted state XOR `out_inv`. With `out_inv`=0 the output is active high; with `out_inv`=1 it is active low. A change of `out_inv` takes effect at the pin at once.
- R8: `rst_n`=0 or `cnt_clr`=1 at an edge sets the count to 0 and the output to its inactive level (equal to `out_inv`). `cnt_clr` has priority over a count clock at the same edge, and that count clock produces no match.
- R9: A match is an event of a count clock: it occurs only on an edge with `run`=1 and `cnt_en`=1 while the count equals the compare value. Cycles without a count clock cause no match, even when the count equals a compare value.
- R10: Flag bit 0 is set by a compare A match and flag bit 1 by a compare B match. A flag stays set until a 1 on the matching bit of `flag_clr`. A match wins over a clear at the same edge. Reset clears both flags; `cnt_clr` does not.
- R11: `irq` = (flag0 AND `irq_en[0]`) OR (flag1 AND `irq_en[1]`). It follows a change of `irq_en` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Single-cycle count-clock enable pulse |
| run | input | 1 | Run enable for the counter |
| cnt_clr | input | 1 | Synchronous counter reset; also forces the pin inactive |
| cmp_a | input | CNT_W | Compare A value |
| cmp_b | input | CNT_W | Compare B value (period end) |
| out_mode | input | 2 | Output action on matches: 0 off, 1 set A/clear B, 2 toggle A, 3 toggle B |
| out_inv | input | 1 | 1 selects an active-low output |
| irq_en | input | 2 | Interrupt enables: bit 0 compare A, bit 1 compare B |
| flag_clr | input | 2 | Flag clear strobes: bit 0 compare A, bit 1 compare B |
| count | output | CNT_W | Current counter value |
| wave_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The count, the internal output state and the flags are all registered. Each of them shows the effect of a count clock, a match or a clear one clock after the edge at which the stimulus is sampled. The `out_inv` and `irq_en` inputs act combinationally, so their effect is visible in the same cycle.

The bench changes inputs just after a falling edge. It updates its behavioural model at the rising edge from those inputs, and compares every output at the following falling edge. Each compare therefore sees exactly one registered step, together with the current combinational inputs.

// File: rtl/cwt_pkg.sv
// Shared types for the dual-compare waveform timer.
// Assumes: the mode encoding below is the one driven on out_mode.
package cwt_pkg;

    // Output action selected for compare matches
    typedef enum logic [1:0] {
        WAVE_OFF    = 2'd0,
        WAVE_SETCLR = 2'd1,
        WAVE_TGL_A  = 2'd2,
        WAVE_TGL_B  = 2'd3
    } wave_mode_e;

    localparam int unsigned N_CMP = 2;
    localparam int unsigned CMP_A = 0;
    localparam int unsigned CMP_B = 1;

endpackage

// File: rtl/cwt_counter.sv
// Period counter: counts count-clock ticks and wraps to zero after the
// tick that arrives while the count equals the limit.
// Assumes: clr has priority over tick; reset is synchronous, active low.
module cwt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    // Advance, wrap or clear the period count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else if (clr) begin
            cnt <= ZERO;
        end else if (tick) begin
            cnt <= (cnt == limit) ? ZERO : cnt + ONE;
        end
    end

endmodule

// File: rtl/cwt_wave.sv
// Output shaper: holds the non-inverted pin state and applies the mode
// action on compare match pulses; polarity is applied combinationally.
// Assumes: hit_a/hit_b are single-cycle pulses already gated by clr.
module cwt_wave
    import cwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] mode,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       inv,
    output logic       pin
);

    wave_mode_e mode_e;
    logic       state;

    // Decode the raw mode field
    always_comb mode_e = wave_mode_e'(mode);

    // Update the non-inverted output state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= 1'b0;
        end else if (clr) begin
            state <= 1'b0;
        end else begin
            unique case (mode_e)
                WAVE_OFF:    state <= 1'b0;
                WAVE_SETCLR: begin
                    if (hit_b)      state <= 1'b0;
                    else if (hit_a) state <= 1'b1;
                end
                WAVE_TGL_A:  if (hit_a) state <= ~state;
                WAVE_TGL_B:  if (hit_b) state <= ~state;
                default:     state <= 1'b0;
            endcase
        end
    end

    // Apply polarity at the pin
    assign pin = state ^ inv;

endmodule

// File: rtl/cwt_irq.sv
// Interrupt flags: one sticky flag per compare source, cleared by strobe,
// combined through per-source enables into a single request.
// Assumes: a set and a clear at the same edge leave the flag set.
module cwt_irq #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set,
    input  logic [N_SRC-1:0] clr,
    input  logic [N_SRC-1:0] en,
    output logic             req
);

    logic [N_SRC-1:0] flag;

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        // Hold one source flag until its clear strobe
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[g] <= 1'b0;
            else if (set[g]) flag[g] <= 1'b1;
            else if (clr[g]) flag[g] <= 1'b0;
        end
    end

    // Combine enabled flags into the request
    assign req = |(flag & en);

endmodule

// File: rtl/cwt_top.sv
// Dual-compare waveform timer top: counter, two comparators, output
// shaper and interrupt flags.
// Assumes: cnt_en is a single-cycle pulse per count clock.
module cwt_top
    import cwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             run,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [1:0]       out_mode,
    input  logic             out_inv,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             wave_out,
    output logic             irq
);

    logic             tick;
    logic [CNT_W-1:0] cmp_vec [N_CMP];
    logic [N_CMP-1:0] hit;

    // Qualify the count clock with the run enable
    assign tick = run & cnt_en;

    assign cmp_vec[CMP_A] = cmp_a;
    assign cmp_vec[CMP_B] = cmp_b;

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        // One match pulse per count clock that finds the count equal
        assign hit[g] = tick & ~cnt_clr & (count == cmp_vec[g]);
    end

    cwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .limit (cmp_b),
        .cnt   (count)
    );

    cwt_wave u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .mode  (out_mode),
        .hit_a (hit[CMP_A]),
        .hit_b (hit[CMP_B]),
        .inv   (out_inv),
        .pin   (wave_out)
    );

    cwt_irq #(.N_SRC(N_CMP)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clr   (flag_clr),
        .en    (irq_en),
        .req   (irq)
    );

endmodule

// File: rtl/cwt_chk.sv
// Property checker for cwt_top, attached through bind.
// Assumes: it sees only the top-level ports.
module cwt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             run,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_b,
    input logic [1:0]       out_mode,
    input logic             out_inv,
    input logic [1:0]       irq_en,
    input logic [1:0]       flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             wave_out,
    input logic             irq
);

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && cnt_en) && !cnt_clr) |=> $stable(count));

    // R2
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_en && !cnt_clr && count == cmp_b) |=> (count == '0));

    // R8
    clr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count == '0 && wave_out == out_inv));

    // R3
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd0) |=> (wave_out == out_inv));

    // R6
    tgl_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd3 && run && cnt_en && !cnt_clr && count == cmp_b)
        |=> ((wave_out ^ out_inv) != $past(wave_out ^ out_inv)));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);

endmodule

bind cwt_top cwt_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cwt_top.sv
`timescale 1ns/1ps
module sim_cwt_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         run = 1'b0;
    logic         cnt_clr = 1'b0;
    logic [W-1:0] cmp_a = 16'd3;
    logic [W-1:0] cmp_b = 16'd5;
    logic [1:0]   out_mode = 2'd0;
    logic         out_inv = 1'b0;
    logic [1:0]   irq_en = 2'b00;
    logic [1:0]   flag_clr = 2'b00;
    logic [W-1:0] count;
    logic         wave_out;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    int m_cnt = 0;
    bit m_st = 0;
    bit m_fa = 0;
    bit m_fb = 0;

    always #2.5 clk = ~clk;

    cwt_top #(.CNT_W(W)) u0 (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string wave_tag();
        if (out_inv) return "R7";
        case (out_mode)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One clock: update the model at the rising edge, compare at the falling edge
    task automatic step();
        bit ea, eb;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_fa = 0; m_fb = 0;
        end else begin
            ea = run && cnt_en && !cnt_clr && (m_cnt == int'(cmp_a));
            eb = run && cnt_en && !cnt_clr && (m_cnt == int'(cmp_b));
            if (cnt_clr) begin
                m_cnt = 0; m_st = 0;
            end else begin
                if (run && cnt_en) m_cnt = (m_cnt == int'(cmp_b)) ? 0 : (m_cnt + 1) % 65536;
                if (out_mode == 2'd0) m_st = 0;
                else if (out_mode == 2'd1) begin
                    if (eb) m_st = 0; else if (ea) m_st = 1;
                end else if (out_mode == 2'd2) begin
                    if (ea) m_st = !m_st;
                end else if (eb) m_st = !m_st;
            end
            m_fa = ea || (m_fa && !flag_clr[0]);
            m_fb = eb || (m_fb && !flag_clr[1]);
        end
        @(negedge clk);
        check(int'(count) == m_cnt, "R1/R2 count", int'(count), m_cnt);
        check(wave_out == (m_st ^ out_inv), wave_tag(), int'(wave_out), int'(m_st ^ out_inv));
        check(irq == ((m_fa && irq_en[0]) || (m_fb && irq_en[1])), "R11 irq",
              int'(irq), int'((m_fa && irq_en[0]) || (m_fb && irq_en[1])));
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cnt_en = 1'b1;
            step();
            cnt_en = 1'b0;
            for (int j = 0; j < gap; j++) step();
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        int seq_exp[8] = '{0, 1, 2, 3, 4, 5, 0, 1};
        @(negedge clk);
        step(); step();
        // R8 reset state
        check(count == 0, "R8 reset count", int'(count), 0);
        check(wave_out == 1'b0, "R8 reset level", int'(wave_out), 0);
        check(irq == 1'b0, "R10 reset flags", int'(irq), 0);
        rst_n = 1'b1;
        step();

        // R2 sequence with A=3, B=5, mode 1 (R4)
        out_mode = 2'd1; run = 1'b1; irq_en = 2'b11;
        for (int i = 0; i < 8; i++) begin
            check(int'(count) == seq_exp[i], "R2 sequence", int'(count), seq_exp[i]);
            cnt_en = 1'b1; step(); cnt_en = 1'b0;
        end
        run_ticks(14, 0);

        // R9 sparse count clocks, mode 2 (R5)
        out_mode = 2'd2;
        run_ticks(15, 2);

        // R6 mode 3 with inversion (R7)
        out_mode = 2'd3; out_inv = 1'b1;
        run_ticks(15, 1);

        // R1 run low blocks count clocks
        run = 1'b0;
        run_ticks(6, 0);
        run = 1'b1;

        // R8 counter clear mid-period, together with a count clock
        run_ticks(2, 0);
        cnt_clr = 1'b1; cnt_en = 1'b1; step(); cnt_en = 1'b0; cnt_clr = 1'b0;
        check(count == 0, "R8 clear count", int'(count), 0);
        check(wave_out == 1'b1, "R8 clear inactive inverted", int'(wave_out), 1);

        // R3 mode off
        out_mode = 2'd0; out_inv = 1'b0;
        run_ticks(12, 0);

        // R4 equal compares: clear wins
        out_mode = 2'd1; cmp_a = 16'd2; cmp_b = 16'd2;
        run_ticks(12, 0);
        cmp_a = 16'd1; cmp_b = 16'd4;
        run_ticks(10, 0);

        // R10/R11 flag hold, clear strobes and enables
        irq_en = 2'b01; step();
        flag_clr = 2'b01; step(); flag_clr = 2'b00;
        irq_en = 2'b10; step();
        flag_clr = 2'b10; step(); flag_clr = 2'b00;
        check(irq == 1'b0, "R10 cleared", int'(irq), 0);
        irq_en = 2'b11;
        run_ticks(3, 3);
        flag_clr = 2'b11; cnt_en = 1'b1; step(); cnt_en = 1'b0; flag_clr = 2'b00;
        run_ticks(8, 1);
        irq_en = 2'b00; step();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule